// File: doc/BRIEF.md
# RTC Counter and Periodic Timer

This block keeps a 48-bit real-time count that advances on a 32768 Hz tick enable. The low fifteen bits of the count are the fraction of a second and the bits above them are whole seconds. Software reads the count through three 16-bit windows. Each window is a 16-bit slice of the count taken from its own bit position, so the first window carries the least significant seconds bit in its top bit.

The block also has a programmable periodic timer. Software loads a 32-bit divisor as two 16-bit halves. That divisor sets the timer period in base ticks. Each time the period runs out, a pending-event counter goes up by one. The interrupt line stays high while that counter is above zero. Each access to the acknowledge register retires one event.

The bus has no wait states. A read returns its data combinationally in the same cycle. A write takes effect at the clock edge that samples it.

Top module: `rtc_period_timer`

## Requirements
- R1: The count goes up by one at every clock edge where `tickEn` is high and holds its value at every other edge.
- R2: A read of address 0x0C0 returns count bits 15:0, so bit 15 of that word is the seconds LSB. A read of 0x0C2 returns count bits 31:16 and a read of 0x0C4 returns count bits 47:32. While `rdEn` is low, or for any other address, `rdData` is zero.
- R3: Address 0x0D0 writes divisor bits 15:0 and address 0x0D2 writes divisor bits 31:16. A write is ignored if it would leave the whole 32-bit divisor at zero.
- R4: From reset the periodic timer is idle, and no events occur until the divisor first becomes nonzero. From then on, with divisor N, an event occurs on the Nth tick enable after the write and then on every Nth tick enable after that.
- R5: A divisor written while the timer is running does not change the current period. It is loaded as the next period when the current one expires.
- R6: Each period expiry adds one to the pending count. `irq` is high exactly while the pending count is nonzero, and it changes at the edge after the event.
- R7: A read or a write of address 0x0DE takes one from the pending count. When the pending count is zero this access has no effect.
- R8: If an expiry and an acknowledge fall in the same cycle, the pending count is left unchanged.
- R9: The pending count saturates at 15 (2^PEND_W-1) and never wraps.
- R10: Reset (`rstN` low, asynchronous) clears the count, the divisor and the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 32768 Hz base tick enable, one clock wide per tick |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 9 | Bus byte address |
| wrData | input | 16 | Bus write data |
| rdData | output | 16 | Bus read data, combinational |
| irq | output | 1 | Periodic interrupt, high while events are pending |

## Verification
The assertions check the following on every cycle:
- the count steps by exactly one on a tick and holds otherwise;
- the period counter steps down by one on each tick;
- a nonzero divisor never returns to zero;
- the pending count holds when an expiry and an acknowledge coincide, and holds at its ceiling;
- `irq` rises after an unopposed expiry and falls after the last acknowledge.

Some behaviour shows only across whole scenarios in the bench:
- the exact tick on which the first and later events land;
- a new divisor waiting for the current period to end;
- the window layout across the seconds boundary;
- how many acknowledges it takes to drain a saturated pending count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Index width of the count read windows (up to four 16-bit windows).
  localparam int WIN_IDX_W = 2;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic                 cntInc;   // advance the real-time count
    logic                 expire;   // period ran out this cycle
    logic                 ack;      // acknowledge access this cycle
    logic                 divLoWr;  // accepted write of divisor low half
    logic                 divHiWr;  // accepted write of divisor high half
    logic                 rdHit;    // read of a count window
    logic [WIN_IDX_W-1:0] rdWin;    // which count window
  } ctrlStrb_t;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int BUS_W    = 16,
  parameter int CNT_W    = 48,
  parameter int CNT_BASE = 'h0C0,
  parameter int DIV_LO_A = 'h0D0,
  parameter int DIV_HI_A = 'h0D2,
  parameter int ACK_A    = 'h0DE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [2*BUS_W-1:0]  nxtDiv,
  output ctrlStrb_t           strb
);

  localparam int DIV_W   = 2 * BUS_W;
  localparam int NUM_WIN = CNT_W / BUS_W;
  localparam int STEP    = BUS_W / 8;

  logic [NUM_WIN-1:0] winHit;
  logic [DIV_W-1:0]   perCnt;
  logic               running;
  logic               hitLo;
  logic               hitHi;
  logic               hitAck;

  // One address comparator per count window.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign winHit[w] = (addr == ADDR_W'(CNT_BASE + w * STEP));
  end

  assign hitLo  = (addr == ADDR_W'(DIV_LO_A));
  assign hitHi  = (addr == ADDR_W'(DIV_HI_A));
  assign hitAck = (addr == ADDR_W'(ACK_A));

  always_comb begin
    strb         = '0;
    strb.cntInc  = tickEn;
    strb.expire  = running && tickEn && (perCnt == '0);
    strb.ack     = (wrEn || rdEn) && hitAck;
    // A write that would leave the whole divisor at zero is dropped.
    strb.divLoWr = wrEn && hitLo && ({nxtDiv[DIV_W-1:BUS_W], wrData} != '0);
    strb.divHiWr = wrEn && hitHi && ({wrData, nxtDiv[BUS_W-1:0]} != '0);
    for (int w = 0; w < NUM_WIN; w++) begin
      if (winHit[w]) begin
        strb.rdHit = rdEn;
        strb.rdWin = WIN_IDX_W'(w);
      end
    end
  end

  // Period down-counter; the divisor is sampled only on start and on expiry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      perCnt  <= '0;
    end else if (!running) begin
      if (nxtDiv != '0) begin
        running <= 1'b1;
        perCnt  <= nxtDiv - 1'b1;
      end
    end else if (tickEn) begin
      perCnt <= (perCnt == '0) ? nxtDiv - 1'b1 : perCnt - 1'b1;
    end
  end

  // R4
  period_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && perCnt != '0) |=> (perCnt == $past(perCnt) - 1'b1));

  // R3
  div_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nxtDiv != '0) |=> (nxtDiv != '0));

  // R5
  period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tickEn) |=> $stable(perCnt));

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int CNT_W  = 48,
  parameter int PEND_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [BUS_W-1:0]    wrData,
  output logic [2*BUS_W-1:0]  nxtDiv,
  output logic [BUS_W-1:0]    rdData,
  output logic                irq
);

  localparam int DIV_W   = 2 * BUS_W;
  localparam int NUM_WIN = CNT_W / BUS_W;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  divReg;
  logic [PEND_W-1:0] pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
    end else begin
      if (strb.divLoWr) divReg[BUS_W-1:0]     <= wrData;
      if (strb.divHiWr) divReg[DIV_W-1:BUS_W] <= wrData;
    end
  end

  assign nxtDiv = divReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      case ({strb.expire, strb.ack})
        2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
        2'b01:   if (pend != '0)       pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign irq = (pend != '0);

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (strb.rdHit && strb.rdWin == WIN_IDX_W'(w))
        rdData = cnt[w*BUS_W +: BUS_W];
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntInc |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntInc |=> $stable(cnt));

  // R8
  pend_tie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && strb.ack) |=> $stable(pend));

  // R9
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend == PEND_MAX && strb.expire && !strb.ack) |=> (pend == PEND_MAX));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !strb.ack) |=> irq);

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && !strb.expire && pend == PEND_W'(1)) |=> !irq);

endmodule

// File: rtl/rtc_period_timer.sv
module rtc_period_timer
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int BUS_W    = 16,
  parameter int CNT_W    = 48,
  parameter int PEND_W   = 4,
  parameter int CNT_BASE = 'h0C0,
  parameter int DIV_LO_A = 'h0D0,
  parameter int DIV_HI_A = 'h0D2,
  parameter int ACK_A    = 'h0DE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              irq
);

  localparam int DIV_W = 2 * BUS_W;

  ctrlStrb_t        strb;
  logic [DIV_W-1:0] nxtDiv;

  rtc_ctrl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W), .CNT_BASE(CNT_BASE),
    .DIV_LO_A(DIV_LO_A), .DIV_HI_A(DIV_HI_A), .ACK_A(ACK_A)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .nxtDiv(nxtDiv), .strb(strb)
  );

  rtc_datapath #(
    .BUS_W(BUS_W), .CNT_W(CNT_W), .PEND_W(PEND_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .nxtDiv(nxtDiv), .rdData(rdData), .irq(irq)
  );

endmodule

// File: tb/rtc_period_timer_bench.sv
`timescale 1ns/1ps
module rtc_period_timer_bench;

  localparam logic [8:0] A_C0 = 9'h0C0, A_C2 = 9'h0C2, A_C4 = 9'h0C4;
  localparam logic [8:0] A_DLO = 9'h0D0, A_DHI = 9'h0D2, A_ACK = 9'h0DE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [47:0] cntModel = '0;

  typedef struct {
    bit          isRead;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  rtc_period_timer u_rtc_period_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // Monitor: pops one expected item per falling edge and compares it.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      got = it.isRead ? rdData : {15'd0, irq};
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic doReset();
    tickEn = 0; wrEn = 0; rdEn = 0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    cntModel = '0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tickEn = 1;
      @(posedge clk); #1 tickEn = 0;
    end
    cntModel += 48'(n);
  endtask

  task automatic tickBurst(int n);
    @(posedge clk); #1 tickEn = 1;
    repeat (n) @(posedge clk);
    #1 tickEn = 0;
    cntModel += 48'(n);
  endtask

  task automatic busWr(logic [8:0] a, logic [15:0] d);
    @(posedge clk); #1 wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic ackRd();
    @(posedge clk); #1 rdEn = 1; addr = A_ACK;
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic rdChk(logic [8:0] a, logic [15:0] e, string tag);
    @(posedge clk); #1 rdEn = 1; addr = a;
    q.push_back('{1'b1, e, tag});
    @(negedge clk);
    @(posedge clk); #1 rdEn = 0;
  endtask

  task automatic irqChk(bit e, string tag);
    @(posedge clk); #1;
    q.push_back('{1'b0, {15'd0, e}, tag});
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R10: reset state
    irqChk(0, "R10");
    rdChk(A_C0, 16'h0000, "R10");
    rdChk(A_C4, 16'h0000, "R2");

    // R1: single ticks
    tick(3);
    rdChk(A_C0, cntModel[15:0], "R1");

    // R3: zero writes are dropped, timer stays idle (R4)
    busWr(A_DLO, 16'h0000);
    busWr(A_DHI, 16'h0000);
    tickBurst(32765);
    rdChk(A_C0, 16'h8000, "R2");
    rdChk(A_C2, 16'h0000, "R2");
    tickBurst(32772);
    rdChk(A_C0, cntModel[15:0], "R2");
    rdChk(A_C2, cntModel[31:16], "R2");
    rdChk(A_C4, cntModel[47:32], "R2");
    irqChk(0, "R4");

    // R4/R6: divisor 5
    busWr(A_DLO, 16'd5);
    tick(4);
    irqChk(0, "R4");
    tick(1);
    irqChk(1, "R6");
    busWr(A_ACK, 16'h0);
    irqChk(0, "R7");

    // R5: new divisor waits for current period
    busWr(A_DLO, 16'd2);
    tick(4);
    irqChk(0, "R5");
    tick(1);
    irqChk(1, "R5");
    busWr(A_ACK, 16'h0);
    tick(1);
    irqChk(0, "R5");
    tick(1);
    irqChk(1, "R5");
    busWr(A_ACK, 16'h0);

    // R8: expiry and acknowledge together
    busWr(A_DLO, 16'd1);
    tick(2);
    irqChk(1, "R6");
    @(posedge clk); #1 tickEn = 1; wrEn = 1; addr = A_ACK; wrData = '0;
    @(posedge clk); #1 tickEn = 0; wrEn = 0;
    cntModel += 48'd1;
    irqChk(1, "R8");
    busWr(A_ACK, 16'h0);
    irqChk(0, "R8");

    // R9: saturation at 15
    tickBurst(20);
    for (int i = 0; i < 13; i++) busWr(A_ACK, 16'h0);
    ackRd();
    irqChk(1, "R9");
    busWr(A_ACK, 16'h0);
    irqChk(0, "R9");
    busWr(A_ACK, 16'h0);
    irqChk(0, "R7");
    tick(1);
    irqChk(1, "R7");
    busWr(A_ACK, 16'h0);
    irqChk(0, "R7");

    // R10: reset mid-run
    tick(2);
    doReset();
    irqChk(0, "R10");
    rdChk(A_C0, 16'h0000, "R10");
    tick(3);
    irqChk(0, "R10");
    rdChk(A_C0, cntModel[15:0], "R1");

    // R3: high half sets divisor 0x10000
    busWr(A_DHI, 16'h0001);
    tickBurst(65535);
    irqChk(0, "R3");
    tick(1);
    irqChk(1, "R3");

    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule